// File: doc/BRIEF.md
# Background Block Differential Formatter

This block sits in front of a transform engine that works on 8x8 pixel blocks. Pixels arrive one per valid cycle, and the first pixel of each block is marked. With that first pixel comes a one-bit block class: object or background. For an object block, the formatter forwards every pixel unchanged, zero-extended by one bit. For a background block, it keeps the first pixel as that block's reference and sends each pixel minus the reference. The transform therefore sees small signed values and spends fewer toggling bits on flat regions.

Subtracting the reference removes a constant offset from the block. That offset has to be restored in the transformed result. On the return path the block takes in the transform coefficients, with the index-0 (DC) coefficient marked. For a background block it adds eight times the reference to the DC term. This is the DC of a constant block under an orthonormal 8x8 DCT-II. All other coefficients pass straight through.

The transform may still hold several blocks when new pixels arrive. To handle this, each block's class and reference go into a small queue when its first pixel arrives. An entry leaves the queue when that block's DC coefficient comes back.

Top module: `bg_delta_formatter`

## Requirements
- R1: For an object block, each sample appears on `smp_data` one clock after it is accepted, equal to the pixel zero-extended to 9 bits, with `smp_valid` high.
- R2: For a background block, each sample is the pixel minus the block reference, as a 9-bit two's-complement value, with one clock of latency.
- R3: The reference and the class are taken from the pixel accepted with `pix_first` high. That pixel's own background sample is 0. The `pix_bg` input is ignored on pixels where `pix_first` is low.
- R4: When `coef_in_first` is high and the oldest queued block is background, `coef_out_data` equals `coef_in_data + 8*reference`, wrapping modulo 2^16. The result appears one clock later.
- R5: When `coef_in_first` is high and the oldest queued block is an object block, the DC coefficient passes unchanged.
- R6: A coefficient with `coef_in_first` low passes unchanged, one clock later, and `coef_out_first` is low with it.
- R7: Up to 4 blocks may have started on the pixel side before their DC coefficients return. The DC corrections use each block's own class and reference, in arrival order.
- R8: After reset, `smp_valid` and `coef_out_valid` are low, and the queue is empty.
- R9: Cycles with `pix_valid` low leave the held reference and class unchanged for the remaining pixels of the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel input valid |
| pix_first | input | 1 | Marks the first pixel of a block |
| pix_bg | input | 1 | Block class, 1 = background; read only with the first pixel |
| pix_data | input | 8 | Unsigned pixel value |
| smp_valid | output | 1 | Formatted sample valid |
| smp_data | output | 9 | Formatted sample, two's complement |
| coef_in_valid | input | 1 | Coefficient from the transform valid |
| coef_in_first | input | 1 | Marks the DC coefficient of a block |
| coef_in_data | input | 16 | Signed coefficient from the transform |
| coef_out_valid | output | 1 | Corrected coefficient valid |
| coef_out_first | output | 1 | DC marker, delayed with the data |
| coef_out_data | output | 16 | Corrected coefficient |

## Verification
The hardest case to reach is a full queue, with four blocks of mixed class and different references waiting before any DC returns. The bench streams four blocks through the pixel side first: one object block and three background blocks with references 100, 0 and 255. Only then does it return the DC and AC coefficients, so each correction must come from the matching queue entry. A final background block uses reference 1 with a DC coefficient at the positive limit, to exercise the 16-bit wrap.

// File: rtl/bg_delta_formatter.sv
module bg_delta_formatter #(
  parameter int PW     = 8,
  parameter int CW     = 16,
  parameter int BLK    = 8,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_valid,
  input  logic          pix_first,
  input  logic          pix_bg,
  input  logic [PW-1:0] pix_data,
  output logic          smp_valid,
  output logic [PW:0]   smp_data,
  input  logic          coef_in_valid,
  input  logic          coef_in_first,
  input  logic [CW-1:0] coef_in_data,
  output logic          coef_out_valid,
  output logic          coef_out_first,
  output logic [CW-1:0] coef_out_data
);
  localparam int AW    = $clog2(QDEPTH);
  localparam int SHIFT = $clog2(BLK);
  localparam int PADW  = CW - PW - SHIFT;

  logic [PW-1:0] ref_q;
  logic          bg_q;
  logic [PW-1:0] q_ref [QDEPTH];
  logic          q_bg  [QDEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;

  wire          push    = pix_valid & pix_first;
  wire          pop     = coef_in_valid & coef_in_first;
  wire [AW:0]   count   = wr_ptr - rd_ptr;
  wire          q_empty = (count == '0);
  wire          q_full  = (count == (AW+1)'(QDEPTH));

  wire [PW-1:0] cur_ref = pix_first ? pix_data : ref_q;
  wire          cur_bg  = pix_first ? pix_bg : bg_q;
  wire [PW:0]   raw     = {1'b0, pix_data};
  wire [PW:0]   delta   = raw - {1'b0, cur_ref};

  wire [PW-1:0] head_ref = q_ref[rd_ptr[AW-1:0]];
  wire          head_bg  = q_bg[rd_ptr[AW-1:0]];
  wire [CW-1:0] dc_add   = {{PADW{1'b0}}, head_ref, {SHIFT{1'b0}}};
  wire          fix_dc   = pop & ~q_empty & head_bg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q     <= '0;
      bg_q      <= 1'b0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      smp_valid <= pix_valid;
      if (pix_valid) smp_data <= cur_bg ? delta : raw;
      if (push) begin
        ref_q <= pix_data;
        bg_q  <= pix_bg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop && !q_empty) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_ref[wr_ptr[AW-1:0]] <= pix_data;
      q_bg[wr_ptr[AW-1:0]]  <= pix_bg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_out_valid <= 1'b0;
      coef_out_first <= 1'b0;
      coef_out_data  <= '0;
    end else begin
      coef_out_valid <= coef_in_valid;
      coef_out_first <= coef_in_valid & coef_in_first;
      if (coef_in_valid) coef_out_data <= fix_dc ? coef_in_data + dc_add : coef_in_data;
    end
  end

  p_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> smp_valid);
  p_obj_raw_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_first && !pix_bg |=> smp_data == {1'b0, $past(pix_data)});
  p_first_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_first && pix_bg |=> smp_data == '0);
  p_ac_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    coef_in_valid && !coef_in_first |=> coef_out_valid && !coef_out_first
                                        && coef_out_data == $past(coef_in_data));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && q_full && !pop));
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !q_empty);
  p_rst_idle_r8: assert property (@(posedge clk)
    !rst_n |=> !smp_valid && !coef_out_valid);
endmodule

// File: tb/bg_delta_formatter_bench.sv
`timescale 1ns/1ps
module bg_delta_formatter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 0, pix_first = 0, pix_bg = 0;
  logic [7:0] pix_data = '0;
  logic smp_valid;
  logic [8:0] smp_data;
  logic coef_in_valid = 0, coef_in_first = 0;
  logic [15:0] coef_in_data = '0;
  logic coef_out_valid, coef_out_first;
  logic [15:0] coef_out_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bg_delta_formatter u_bg_delta_formatter (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_first(pix_first), .pix_bg(pix_bg), .pix_data(pix_data),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .coef_in_valid(coef_in_valid), .coef_in_first(coef_in_first), .coef_in_data(coef_in_data),
    .coef_out_valid(coef_out_valid), .coef_out_first(coef_out_first), .coef_out_data(coef_out_data)
  );

  // {first, bg, pixel, expected sample}
  localparam int NV = 10;
  localparam logic [18:0] TV [NV] = '{
    {1'b1, 1'b0, 8'd200, 9'd200},
    {1'b0, 1'b1, 8'd9,   9'd9},
    {1'b0, 1'b0, 8'd255, 9'd255},
    {1'b1, 1'b1, 8'd100, 9'd0},
    {1'b0, 1'b0, 8'd110, 9'd10},
    {1'b0, 1'b0, 8'd90,  9'h1F6},
    {1'b0, 1'b0, 8'd0,   9'h19C},
    {1'b1, 1'b1, 8'd0,   9'd0},
    {1'b0, 1'b0, 8'd255, 9'd255},
    {1'b1, 1'b1, 8'd255, 9'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pix(input logic f, input logic b, input logic [7:0] d,
                     input logic [8:0] exp, input string req);
    @(negedge clk);
    pix_valid = 1; pix_first = f; pix_bg = b; pix_data = d;
    @(negedge clk);
    pix_valid = 0; pix_first = 0; pix_bg = 0;
    check(req, {31'd0, smp_valid}, 32'd1);
    check(req, {23'd0, smp_data}, {23'd0, exp});
    @(negedge clk);
  endtask

  task automatic coef(input logic f, input logic [15:0] d,
                      input logic [15:0] exp, input string req);
    @(negedge clk);
    coef_in_valid = 1; coef_in_first = f; coef_in_data = d;
    @(negedge clk);
    coef_in_valid = 0; coef_in_first = 0;
    check(req, {30'd0, coef_out_valid, coef_out_first}, {30'd0, 1'b1, f});
    check(req, {16'd0, coef_out_data}, {16'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8", {30'd0, smp_valid, coef_out_valid}, 32'd0);
    rst_n = 1;
    // Table walk: R1/R2/R3 samples; idle gaps between entries cover R9
    for (int i = 0; i < NV; i++) begin
      logic [18:0] v;
      v = TV[i];
      pix(v[18], v[17], v[16:9], v[8:0],
          (v[18] || v[17]) ? ((v[18]) ? "R3" : "R2 R9") : "R1");
    end
    // four blocks in flight: obj(200), bg(100), bg(0), bg(255)
    coef(1'b1, 16'd1000, 16'd1000, "R5 R7");
    coef(1'b0, 16'hFFFD, 16'hFFFD, "R6");
    coef(1'b1, 16'd1000, 16'd1800, "R4 R7");
    coef(1'b0, 16'd50, 16'd50, "R6");
    coef(1'b1, 16'd1000, 16'd1000, "R7");
    coef(1'b1, 16'd1000, 16'd3040, "R4 R7");
    // wrap of the DC correction
    pix(1'b1, 1'b1, 8'd1, 9'd0, "R3");
    coef(1'b1, 16'h7FFF, 16'h8007, "R4");
    @(negedge clk);
    check("R6", {31'd0, coef_out_valid}, 32'd0);
    // reset again mid-run
    rst_n = 0;
    @(negedge clk);
    check("R8", {30'd0, smp_valid, coef_out_valid}, 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule